// File: doc/BRIEF.md
# Core Tick Timer with Period Match Interrupt

This block is a per-core tick timer. Software reaches it through a small register port made of an address, a write strobe, write data and combinational read data. It holds a 32-bit cycle counter and a control word. The control word holds a two-bit run mode, an interrupt-enable bit, a sticky pending bit and a 28-bit match period. When the low 28 bits of the counter equal the period, the block records a match. If interrupts are enabled, it raises a level interrupt toward the core.

The run mode decides what the counter does at a match. In free-running mode the counter keeps going, so the block can serve as a time base and as a one-shot event source at the same time. Software arms the next event by writing a period that is a future value of the low counter bits. Software acknowledges the interrupt by rewriting the control word with only the run-mode bits set. This clears the pending bit and the enable bit while counting goes on. A constant presence output, also readable through a capability register, tells software that the timer exists.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-low reset the control word reads 0 (mode off, enable 0, pending 0, period 0), the counter reads 0 and `irq` is 0.
- R2: In every mode other than off, the counter adds 1 per clock unless the mode rule says otherwise, and it wraps from 0xFFFFFFFF to 0. In mode off (code 00) it holds its value.
- R3: A write to the counter address loads the written value on that edge. The write takes priority over increment, clear and hold.
- R4: A match exists when the mode is not off and counter bits [27:0] equal the period field. Counter bits [31:28] play no part. With enable set and the counter starting at a value whose low bits are 0, `irq` first reads 1 after P+1 clock edges for period P.
- R5: Pending (control bit 28) is set on a clock edge where a match exists and enable (bit 29) is 1. Pending stays set until it is written to 0. `irq` equals pending AND enable.
- R6: With enable at 0, a match leaves pending at 0 and `irq` at 0.
- R7: Writing the control word with only the mode field (bits [31:30]) set clears pending and enable and drops `irq` on the next edge, while the counter keeps running.
- R8: In restart mode (code 01) the counter is cleared to 0 on the edge after a match, so it counts modulo P+1.
- R9: In one-shot mode (code 10) the counter stops at the matching value and holds it.
- R10: A control-word write on an edge that also sees a match takes the written pending value.
- R11: Register map: address 0 is the control word {mode[31:30], enable[29], pending[28], period[27:0]}, which reads back as written. Address 1 is the counter. Address 2 is the read-only capability word, with bit 0 equal to 1. Other addresses read 0. `timer_present` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Level interrupt, pending AND enable |
| timer_present | output | 1 | Constant 1, timer is included |

## Verification
The bound checker watches the counter's step rule on every cycle. It checks the hold in mode off, the +1 in free-running mode, the clear after a match in restart mode and the hold at a match in one-shot mode. It also checks that a counter write loads the written value, and that pending only rises after a match with enable set or after a control write. End-to-end timing can only be shown by the bench's scenarios. These are the P+1-edge delay from arming to `irq` across a sweep of periods and upper counter bits, the acknowledge sequence, the read-back layout and the ignored capability write.

// File: rtl/tick_timer_pkg.sv
// Shared types for the tick timer: run-mode codes and register addresses.
package tick_timer_pkg;
    typedef enum logic [1:0] {
        TT_OFF     = 2'b00,
        TT_RESTART = 2'b01,
        TT_ONESHOT = 2'b10,
        TT_FREE    = 2'b11
    } tt_mode_e;

    localparam int TT_A_CTRL  = 0;
    localparam int TT_A_COUNT = 1;
    localparam int TT_A_CAPS  = 2;
endpackage

// File: rtl/tt_counter.sv
// Cycle counter with per-mode behaviour at a period match.
// Assumes: a load request outranks every mode rule; match is not flagged in mode off.
module tt_counter
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PER_W = CNT_W - 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tt_mode_e         mode,
    input  logic [PER_W-1:0] period,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             match
);
    // Compare only the low period-width bits of the counter.
    always_comb match = (mode != TT_OFF) && (count[PER_W-1:0] == period);

    // Advance, clear, hold or load the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else begin
            unique case (mode)
                TT_OFF:     count <= count;
                TT_RESTART: count <= match ? '0 : count + CNT_W'(1);
                TT_ONESHOT: count <= match ? count : count + CNT_W'(1);
                default:    count <= count + CNT_W'(1);
            endcase
        end
    end
endmodule

// File: rtl/tt_ctrl.sv
// Control word: run mode, interrupt enable, sticky pending flag and match period.
// Assumes: a write replaces every field, including pending, even on a match edge.
module tt_ctrl
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PER_W = CNT_W - 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             match,
    output tt_mode_e         mode,
    output logic             ie,
    output logic             pend,
    output logic [PER_W-1:0] period
);
    // Hold the fields; set pending on an enabled match unless software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= TT_OFF;
            ie     <= 1'b0;
            pend   <= 1'b0;
            period <= '0;
        end else if (wr) begin
            mode   <= tt_mode_e'(wdata[CNT_W-1 -: 2]);
            ie     <= wdata[CNT_W-3];
            pend   <= wdata[CNT_W-4];
            period <= wdata[PER_W-1:0];
        end else if (match && ie) begin
            pend   <= 1'b1;
        end
    end
endmodule

// File: rtl/tt_regmux.sv
// Read-data multiplexer for the register port.
// Assumes: reads have no side effects; unmapped addresses read zero.
module tt_regmux
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PER_W  = CNT_W - 4,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  tt_mode_e          mode,
    input  logic              ie,
    input  logic              pend,
    input  logic [PER_W-1:0]  period,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  rdata
);
    localparam logic [CNT_W-1:0] CAPS_WORD = CNT_W'(1);

    // Select the addressed register.
    always_comb begin
        if (int'(addr) == TT_A_CTRL)       rdata = {mode, ie, pend, period};
        else if (int'(addr) == TT_A_COUNT) rdata = count;
        else if (int'(addr) == TT_A_CAPS)  rdata = CAPS_WORD;
        else                               rdata = '0;
    end
endmodule

// File: rtl/tick_timer.sv
// Tick timer top: register decode plus counter, control word and read mux.
// Assumes: one clock domain; reg_rdata is combinational from reg_addr.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              timer_present
);
    localparam int PER_W = CNT_W - 4;

    logic             ctrl_wr;
    logic             cnt_wr;
    logic             match;
    tt_mode_e         mode;
    logic             ie;
    logic             pend;
    logic [PER_W-1:0] period;
    logic [CNT_W-1:0] count;

    // Decode register writes.
    always_comb begin
        ctrl_wr = reg_we && (int'(reg_addr) == TT_A_CTRL);
        cnt_wr  = reg_we && (int'(reg_addr) == TT_A_COUNT);
    end

    tt_counter #(.CNT_W(CNT_W), .PER_W(PER_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .mode(mode), .period(period),
        .load(cnt_wr), .load_val(reg_wdata), .count(count), .match(match)
    );

    tt_ctrl #(.CNT_W(CNT_W), .PER_W(PER_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(reg_wdata),
        .match(match), .mode(mode), .ie(ie), .pend(pend), .period(period)
    );

    tt_regmux #(.CNT_W(CNT_W), .PER_W(PER_W), .ADDR_W(ADDR_W)) u_mux (
        .addr(reg_addr), .mode(mode), .ie(ie), .pend(pend),
        .period(period), .count(count), .rdata(reg_rdata)
    );

    // Level interrupt and presence flag.
    always_comb begin
        irq           = pend & ie;
        timer_present = 1'b1;
    end
endmodule

// File: rtl/tick_timer_checker.sv
// Checker for the tick timer, attached to every tick_timer instance by bind.
module tick_timer_checker
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [CNT_W-1:0]  reg_wdata,
    input logic [CNT_W-1:0]  count,
    input logic              match,
    input tt_mode_e          mode,
    input logic              ie,
    input logic              pend
);
    logic cwr, mwr;
    always_comb begin
        cwr = reg_we && (int'(reg_addr) == TT_A_COUNT);
        mwr = reg_we && (int'(reg_addr) == TT_A_CTRL);
    end

    assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TT_OFF && !cwr) |=> $stable(count));

    assert_free_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TT_FREE && !cwr) |=> count == $past(count) + CNT_W'(1));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cwr |=> count == $past(reg_wdata));

    assert_restart_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TT_RESTART && match && !cwr) |=> count == '0);

    assert_oneshot_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TT_ONESHOT && match && !cwr) |=> $stable(count));

    assert_pend_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> ($past(mwr) || $past(match && ie)));
endmodule

bind tick_timer tick_timer_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .count(count), .match(match), .mode(mode),
    .ie(ie), .pend(pend)
);

// File: tb/test_tick_timer.sv
// Self-checking bench for tick_timer: period sweep plus mode scenarios.
module test_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        timer_present;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_CAPS = 2'd2;
    localparam logic [1:0] M_OFF = 2'b00, M_RST = 2'b01, M_ONE = 2'b10, M_FREE = 2'b11;

    always #10 clk = ~clk;

    tick_timer i_tick_timer (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .timer_present(timer_present)
    );

    function automatic logic [31:0] ctl(logic [1:0] m, logic en, logic pd, logic [27:0] p);
        return {m, en, pd, p};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, c1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        rd(A_CTRL, v); check("R1 ctrl", v, 32'd0);
        rd(A_CNT, v);  check("R1 count", v, 32'd0);
        // R11 presence and map
        check("R11 present", {31'd0, timer_present}, 32'd1);
        rd(A_CAPS, v); check("R11 caps", v, 32'd1);

        // R2 off mode holds
        wr(A_CNT, 32'd5);
        step(8);
        rd(A_CNT, v); check("R2 off hold", v, 32'd5);

        // R2 free-running increment
        wr(A_CNT, 32'd100);
        wr(A_CTRL, ctl(M_FREE, 1'b0, 1'b0, 28'hFFFFFFF));
        step(37);
        rd(A_CNT, v); check("R2 increment", v, 32'd137);

        // R3 load wins over increment, R2 wrap
        wr(A_CNT, 32'hFFFF_FFFF);
        rd(A_CNT, v); check("R3 load", v, 32'hFFFF_FFFF);
        step(1);
        rd(A_CNT, v); check("R2 wrap", v, 32'd0);

        // R4 sweep of periods and upper counter bits
        for (int p = 0; p < 21; p++) begin
            logic [31:0] base;
            int n;
            base = 32'((p % 16)) << 28;
            wr(A_CTRL, 32'd0);
            wr(A_CNT, base);
            wr(A_CTRL, ctl(M_FREE, 1'b1, 1'b0, 28'(p)));
            n = 0;
            for (int k = 0; k < 100; k++) begin
                @(posedge clk);
                #1;
                n++;
                if (irq) break;
            end
            check("R4 irq delay", 32'(n), 32'(p + 1));
            rd(A_CNT, v); check("R4 count at irq", v, base + 32'(p + 1));
            rd(A_CTRL, v); check("R5 pending set", {31'd0, v[28]}, 32'd1);
        end

        // R5 sticky past the match
        step(40);
        check("R5 sticky irq", {31'd0, irq}, 32'd1);

        // R7 acknowledge
        wr(A_CTRL, ctl(M_FREE, 1'b0, 1'b0, 28'd0));
        check("R7 irq low", {31'd0, irq}, 32'd0);
        rd(A_CTRL, v); check("R7 pending clear", {31'd0, v[28]}, 32'd0);
        rd(A_CNT, c1);
        step(5);
        rd(A_CNT, v); check("R7 still counting", v, c1 + 32'd5);

        // R6 enable off
        wr(A_CTRL, 32'd0);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, ctl(M_FREE, 1'b0, 1'b0, 28'd3));
        step(12);
        check("R6 irq", {31'd0, irq}, 32'd0);
        rd(A_CTRL, v); check("R6 pending", {31'd0, v[28]}, 32'd0);

        // R8 restart mode
        wr(A_CTRL, 32'd0);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, ctl(M_RST, 1'b0, 1'b0, 28'd4));
        step(5);
        rd(A_CNT, v); check("R8 cleared", v, 32'd0);
        step(7);
        rd(A_CNT, v); check("R8 modulo", v, 32'd2);

        // R9 one-shot
        wr(A_CTRL, 32'd0);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, ctl(M_ONE, 1'b1, 1'b0, 28'd4));
        step(4);
        rd(A_CNT, v); check("R9 reach", v, 32'd4);
        step(10);
        rd(A_CNT, v); check("R9 stopped", v, 32'd4);
        check("R9 irq", {31'd0, irq}, 32'd1);

        // R10 write beats pending set on a match edge
        wr(A_CTRL, ctl(M_ONE, 1'b1, 1'b0, 28'd4));
        rd(A_CTRL, v); check("R10 pending written", {31'd0, v[28]}, 32'd0);
        check("R10 irq low", {31'd0, irq}, 32'd0);
        step(1);
        check("R10 re-set", {31'd0, irq}, 32'd1);

        // R3 load wins over one-shot hold
        wr(A_CNT, 32'd50);
        rd(A_CNT, v); check("R3 load over hold", v, 32'd50);
        step(3);
        rd(A_CNT, v); check("R3 resumes", v, 32'd53);

        // R11 map details
        wr(A_CTRL, ctl(M_OFF, 1'b1, 1'b0, 28'h0ABCDEF));
        rd(A_CTRL, v); check("R11 ctrl readback", v, ctl(M_OFF, 1'b1, 1'b0, 28'h0ABCDEF));
        wr(A_CAPS, 32'd0);
        rd(A_CAPS, v); check("R11 caps read-only", v, 32'd1);
        rd(2'd3, v); check("R11 unmapped", v, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule